// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers six internal interrupt sources and one external request line into a single processor interrupt request. Each internal source is a sticky flag with a fixed rank: line 0 is level 1, the most urgent, and line 5 is level 6, the least urgent. Internal sources always win over the external one. When the processor starts an interrupt-acknowledge read, the block captures the most urgent pending source. It then supplies a one-byte restart opcode that carries that level.

An internal source is served entirely by the block: it drives the vector and raises a ready indication that releases the processor from its wait state. If nothing internal is pending, the cycle goes to the inter-module bus. The block raises an acknowledge strobe and waits for the interrupting module to respond. If no response arrives within a bounded number of cycles, ready is forced so that the processor cannot hang.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle high pulse on `int_req[i]` sets a pending flag that stays set until its vector is delivered. `cpu_irq` is high whenever any flag is pending or `ext_req` is high, and no acknowledge cycle is in progress.
- R2: An acknowledge cycle begins when both `inta` and `dbin` are high while idle. At that edge the lowest-numbered pending line is captured, and line i is level i+1. Any internal flag takes precedence over `ext_req`.
- R3: The vector byte is binary 11LLL111, where LLL is the captured level. Level 1 gives 0xCF, level 3 gives 0xDF and level 6 gives 0xF7.
- R4: `vec_oe` is high, and `vec_data` carries the vector, only during an internal cycle while `inta` and `dbin` are both high. Otherwise `vec_oe` is 0 and `vec_data` is 0.
- R5: The captured level does not change until `dbin` falls, even if a more urgent request arrives during the cycle.
- R6: Only the delivered flag is cleared at capture. Other pending flags stay set and are served by later cycles in rank order.
- R7: In an internal cycle, `rdy` is high from the first clock after capture until the cycle ends, and `bus_ack` stays low.
- R8: In an external cycle, `bus_ack` is high and `vec_oe` is low. `rdy` stays low until `ext_resp` is sampled high, and rises one clock later.
- R9: If `ext_resp` has not been seen within `RESP_TIMEOUT` clocks of capture, `rdy` is forced high on the clock that ends that window.
- R10: `cpu_irq` is low throughout an acknowledge cycle. The block returns to idle on the first clock at which `dbin` is sampled low.
- R11: Synchronous reset clears all pending flags. While idle after reset, `cpu_irq`, `vec_oe`, `vec_data`, `rdy` and `bus_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | N_LVL | Internal request pulses; bit 0 is the most urgent |
| ext_req | input | 1 | External interrupt request (level) |
| inta | input | 1 | Processor interrupt-acknowledge status |
| dbin | input | 1 | Processor data-in strobe |
| ext_resp | input | 1 | Response from the interrupting module on the bus |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_oe | output | 1 | Vector byte valid on `vec_data` |
| vec_data | output | 8 | Restart opcode carrying the level |
| rdy | output | 1 | Ends the processor wait state |
| bus_ack | output | 1 | Acknowledge strobe onto the inter-module bus |

## Verification
A pending flag that is wrongly cleared or kept shows up on the next acknowledge cycle: the vector byte carries the wrong level, or `cpu_irq` stays high or low after `dbin` falls. A fault in the cycle state shows within one clock of capture, through `rdy`, `bus_ack` and `vec_oe` disagreeing about whether the cycle is internal or external. A faulty response counter changes the exact clock on which a forced `rdy` appears. The tests sample that edge and the one before it.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;

    localparam int LVL_W = 3;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_INT  = 2'd1,
        CYC_EXT  = 2'd2
    } cyc_e;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
    } grant_t;

    function automatic logic [7:0] restart_op(input logic [LVL_W-1:0] lvl);
        return {2'b11, lvl, 3'b111};
    endfunction

endpackage

// File: rtl/irqv_pending.sv
`timescale 1ns/1ps
module irqv_pending
    import irqv_pkg::*;
#(
    parameter int N_LVL = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_LVL-1:0] req,
    input  logic             clr_en,
    output logic [N_LVL-1:0] pend,
    output grant_t           grant
);

    logic [N_LVL-1:0] win_oh;

    // rank order: lowest index wins
    always_comb begin
        logic found;
        found  = 1'b0;
        win_oh = '0;
        grant  = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (pend[i] && !found) begin
                win_oh[i]   = 1'b1;
                grant.valid = 1'b1;
                grant.lvl   = LVL_W'(i + 1);
                found       = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N_LVL; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend[g] <= 1'b0;
            else
                pend[g] <= req[g] | (pend[g] & ~(clr_en & win_oh[g]));
        end
    end

    AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> (($past(pend) & ~$past(win_oh) & ~pend) == '0)); // R6

    AST_CLR_HAS_WINNER: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> grant.valid); // R2

endmodule

// File: rtl/irqv_cycle_fsm.sv
`timescale 1ns/1ps
module irqv_cycle_fsm
    import irqv_pkg::*;
#(
    parameter int RESP_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inta,
    input  logic             dbin,
    input  grant_t           grant,
    input  logic             ext_resp,
    output cyc_e             state,
    output logic [LVL_W-1:0] cap_lvl,
    output logic             clr_en,
    output logic             rdy,
    output logic             bus_ack
);

    localparam int CNT_W = $clog2(RESP_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESP_TIMEOUT - 1);

    logic             start;
    logic [CNT_W-1:0] cnt;
    logic             resp_seen;
    logic             timed_out;

    assign start   = (state == CYC_IDLE) && inta && dbin;
    assign clr_en  = start && grant.valid;
    assign bus_ack = (state == CYC_EXT);
    assign rdy     = (state == CYC_INT) ||
                     ((state == CYC_EXT) && (resp_seen || timed_out));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CYC_IDLE;
            cap_lvl   <= '0;
            cnt       <= '0;
            resp_seen <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            unique case (state)
                CYC_IDLE: begin
                    if (start) begin
                        state     <= grant.valid ? CYC_INT : CYC_EXT;
                        cap_lvl   <= grant.valid ? grant.lvl : '0;
                        cnt       <= '0;
                        resp_seen <= 1'b0;
                        timed_out <= 1'b0;
                    end
                end
                CYC_INT: begin
                    if (!dbin) state <= CYC_IDLE;
                end
                CYC_EXT: begin
                    if (!dbin) begin
                        state <= CYC_IDLE;
                    end else if (!resp_seen && !timed_out) begin
                        if (ext_resp)
                            resp_seen <= 1'b1;
                        else if (cnt == CNT_LAST)
                            timed_out <= 1'b1;
                        else
                            cnt <= cnt + 1'b1;
                    end
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end

    AST_LVL_HELD: assert property (@(posedge clk) disable iff (rst)
        (state != CYC_IDLE && $past(state != CYC_IDLE)) |-> $stable(cap_lvl)); // R5

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(RESP_TIMEOUT)); // R9

    AST_TIMEOUT_RDY: assert property (@(posedge clk) disable iff (rst)
        (state == CYC_EXT && cnt == CNT_LAST && !resp_seen && !timed_out
         && dbin && !ext_resp) |=> rdy); // R9

    AST_RESP_RDY: assert property (@(posedge clk) disable iff (rst)
        (state == CYC_EXT && dbin && ext_resp) |=> rdy); // R8

endmodule

// File: rtl/irqv_vector_out.sv
`timescale 1ns/1ps
module irqv_vector_out
    import irqv_pkg::*;
#(
    parameter int N_LVL = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  cyc_e             state,
    input  logic [LVL_W-1:0] cap_lvl,
    input  logic             inta,
    input  logic             dbin,
    output logic             vec_oe,
    output logic [7:0]       vec_data
);

    assign vec_oe   = (state == CYC_INT) && inta && dbin;
    assign vec_data = vec_oe ? restart_op(cap_lvl) : 8'h00;

    AST_VEC_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> (cap_lvl >= LVL_W'(1) && cap_lvl <= LVL_W'(N_LVL))); // R3

endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int N_LVL        = 6,
    parameter int RESP_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_LVL-1:0] int_req,
    input  logic             ext_req,
    input  logic             inta,
    input  logic             dbin,
    input  logic             ext_resp,
    output logic             cpu_irq,
    output logic             vec_oe,
    output logic [7:0]       vec_data,
    output logic             rdy,
    output logic             bus_ack
);

    logic [N_LVL-1:0] pend;
    grant_t           grant;
    logic             clr_en;
    cyc_e             state;
    logic [LVL_W-1:0] cap_lvl;

    irqv_pending #(.N_LVL(N_LVL)) pend_i (
        .clk    (clk),
        .rst    (rst),
        .req    (int_req),
        .clr_en (clr_en),
        .pend   (pend),
        .grant  (grant)
    );

    irqv_cycle_fsm #(.RESP_TIMEOUT(RESP_TIMEOUT)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .inta     (inta),
        .dbin     (dbin),
        .grant    (grant),
        .ext_resp (ext_resp),
        .state    (state),
        .cap_lvl  (cap_lvl),
        .clr_en   (clr_en),
        .rdy      (rdy),
        .bus_ack  (bus_ack)
    );

    irqv_vector_out #(.N_LVL(N_LVL)) vec_i (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .cap_lvl  (cap_lvl),
        .inta     (inta),
        .dbin     (dbin),
        .vec_oe   (vec_oe),
        .vec_data (vec_data)
    );

    assign cpu_irq = (state == CYC_IDLE) && ((|pend) || ext_req);

    AST_VEC_NOT_BUS: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> !bus_ack); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rdy || bus_ack || vec_oe) |-> !cpu_irq); // R10

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

    localparam int N_LVL = 6;
    localparam int TMO   = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [N_LVL-1:0] int_req;
    logic             ext_req, inta, dbin, ext_resp;
    logic             cpu_irq, vec_oe, rdy, bus_ack;
    logic [7:0]       vec_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.N_LVL(N_LVL), .RESP_TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst(rst), .int_req(int_req), .ext_req(ext_req),
        .inta(inta), .dbin(dbin), .ext_resp(ext_resp), .cpu_irq(cpu_irq),
        .vec_oe(vec_oe), .vec_data(vec_data), .rdy(rdy), .bus_ack(bus_ack)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [N_LVL-1:0] m);
        @(negedge clk) int_req = m;
        @(negedge clk) int_req = '0;
    endtask

    task automatic start_ack;
        @(negedge clk) begin inta = 1'b1; dbin = 1'b1; end
        @(negedge clk);
    endtask

    task automatic end_ack;
        @(negedge clk) begin inta = 1'b0; dbin = 1'b0; end
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11", "cpu_irq", cpu_irq, 0);
        chk("R11", "vec_oe", vec_oe, 0);
        chk("R11", "vec_data", vec_data, 0);
        chk("R11", "rdy", rdy, 0);
        chk("R11", "bus_ack", bus_ack, 0);
    endtask

    task automatic t_single;
        pulse_req(6'b100000);
        chk("R1", "cpu_irq after pulse", cpu_irq, 1);
        start_ack();
        chk("R3", "level6 vector", vec_data, 8'hF7);
        chk("R4", "vec_oe in cycle", vec_oe, 1);
        chk("R7", "rdy internal", rdy, 1);
        chk("R7", "bus_ack internal", bus_ack, 0);
        chk("R10", "cpu_irq in cycle", cpu_irq, 0);
        @(negedge clk) inta = 1'b0;
        #1;
        chk("R4", "vec_oe without inta", vec_oe, 0);
        chk("R4", "vec_data without inta", vec_data, 0);
        @(negedge clk) inta = 1'b1;
        #1;
        chk("R4", "vec_oe restored", vec_oe, 1);
        end_ack();
        chk("R10", "rdy after end", rdy, 0);
        chk("R6", "cpu_irq after delivery", cpu_irq, 0);
    endtask

    task automatic t_priority;
        pulse_req(6'b101010);
        start_ack();
        chk("R2", "level2 wins", vec_data, 8'hD7);
        pulse_req(6'b000001);
        repeat (2) @(negedge clk);
        chk("R5", "level held", vec_data, 8'hD7);
        end_ack();
        chk("R6", "others pending", cpu_irq, 1);
        start_ack();
        chk("R2", "late level1", vec_data, 8'hCF);
        end_ack();
        start_ack();
        chk("R6", "level4 next", vec_data, 8'hE7);
        end_ack();
        start_ack();
        chk("R6", "level6 last", vec_data, 8'hF7);
        end_ack();
        chk("R6", "all served", cpu_irq, 0);
    endtask

    task automatic t_ext_resp;
        @(negedge clk) ext_req = 1'b1;
        #1;
        chk("R1", "cpu_irq from ext", cpu_irq, 1);
        start_ack();
        chk("R8", "bus_ack", bus_ack, 1);
        chk("R8", "vec_oe ext", vec_oe, 0);
        chk("R8", "rdy before resp", rdy, 0);
        chk("R10", "cpu_irq ext cycle", cpu_irq, 0);
        repeat (3) @(negedge clk);
        chk("R8", "rdy still low", rdy, 0);
        ext_resp = 1'b1;
        @(negedge clk) ext_resp = 1'b0;
        chk("R8", "rdy after resp", rdy, 1);
        end_ack();
        chk("R10", "idle after dbin low", bus_ack, 0);
        ext_req = 1'b0;
    endtask

    task automatic t_timeout;
        @(negedge clk) ext_req = 1'b1;
        start_ack();
        repeat (TMO - 1) @(negedge clk);
        chk("R9", "rdy before window end", rdy, 0);
        @(negedge clk);
        chk("R9", "rdy forced", rdy, 1);
        chk("R9", "bus_ack held", bus_ack, 1);
        end_ack();
        ext_req = 1'b0;
    endtask

    task automatic t_int_over_ext;
        @(negedge clk) ext_req = 1'b1;
        pulse_req(6'b000100);
        start_ack();
        chk("R2", "internal over ext", vec_data, 8'hDF);
        chk("R7", "no bus_ack", bus_ack, 0);
        end_ack();
        start_ack();
        chk("R2", "ext served after", bus_ack, 1);
        end_ack();
        ext_req = 1'b0;
        @(negedge clk);
        chk("R1", "irq idle clear", cpu_irq, 0);
    endtask

    initial begin
        rst = 1'b1; int_req = '0; ext_req = 0; inta = 0; dbin = 0; ext_resp = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_ext_resp();
        t_timeout();
        t_int_over_ext();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule